// File: doc/BRIEF.md
# Watchdog Timer with Rate Select

This block guards a CPU against software lockup. It is a binary up counter built from two stages: a prescaler and a 16-step final stage. It advances once for every CPU-rate tick. Software must restart it before it wraps. If it wraps, the block raises a one-cycle system reset request, and both stages start again from zero in the same cycle.

Two static configuration inputs set how it behaves. One turns the whole watchdog on or off. The other picks high-speed or low-speed clock mode, and that choice sets the prescaler length, so the period in ticks stays suited to the oscillator. While the device is in power-down, counting stops and the count is kept.

Software restarts the counter by writing a one to the clear bit of a shared oscillator-mode register. That register sits at a fixed address on a simple register write port. The clear bit clears itself, so each write gives exactly one restart. The register also holds three general read/write control bits. Its remaining bits always read zero. The reset input is asynchronous and active low, and it is expected to be released synchronously to the clock.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `wdt_reset` is low.
- R2: In high-speed mode (`cfg_slow` = 0), with no clear, `wdt_reset` pulses once after exactly 2^PRE_HI_BITS × 2^FIN_BITS counted ticks. The pulse appears in the cycle after the edge that takes the last tick.
- R3: In low-speed mode (`cfg_slow` = 1), the same holds with 2^PRE_LO_BITS × 2^FIN_BITS counted ticks.
- R4: `wdt_reset` is high for a single cycle. The count restarts from zero at the wrap, so the next pulse needs another full period.
- R5: Writing a one to bit 6 of the register at address MODE_ADDR restarts the count. The full period is then counted again from the edge after the write.
- R6: A write to MODE_ADDR with bit 6 at zero leaves the count unchanged.
- R7: Bit 6 of `reg_rdata` reads one for the cycle after a write that set it, and then reads zero again.
- R8: Bits 1, 2 and 3 of the register are read/write and hold their value. Bits 0, 4, 5 and 7 always read zero, whatever is written.
- R9: While `powerdown` is high, ticks are not counted and the count is kept. Counting resumes from the same value when `powerdown` falls.
- R10: While `cfg_enable` is low, no reset request is issued and both stages are held at zero. After enabling, a full period is needed before a pulse.
- R11: Cycles with `tick_en` low do not advance the count.
- R12: A write to any address other than MODE_ADDR changes neither the register nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | CPU-rate tick enable; one count per cycle it is high |
| cfg_enable | input | 1 | Static option: 1 turns the watchdog on |
| cfg_slow | input | 1 | Static option: 1 selects low-speed mode (short prescaler) |
| powerdown | input | 1 | High while the device is in power-down; freezes counting |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current value of the oscillator-mode register |
| wdt_reset | output | 1 | One-cycle system reset request on wrap |

## Verification
The bench aims at the exact wrap cycle in both clock modes. A design whose prescaler limit is off by one, or that ignores the mode select, would pulse one tick early or late, or use the wrong period. It restarts the count with the clear bit in the middle of a period. It also writes a zero clear bit and writes to a neighbouring address. A design that clears on any write, or decodes the address loosely, would delay the pulse. Ticks are given during power-down, during idle cycles and while disabled. A design that counts any of them would pulse early, and one that does not hold the stages at zero when disabled would pulse too soon after enabling. The read-back checks catch a clear bit that sticks and reserved bits that can be written.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int REG_W   = 8;
  localparam int CLR_POS = 6;
  localparam int CTL_LSB = 1;
  localparam int CTL_MSB = 3;
  localparam int CTL_W   = CTL_MSB - CTL_LSB + 1;

  typedef struct packed {
    logic             clr;
    logic [CTL_W-1:0] ctl;
  } mode_reg_t;

endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
  import wdt_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hCA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              clr_req
);

  mode_reg_t state_q;
  mode_reg_t state_d;
  logic      hit;

  assign hit = reg_wr && (reg_addr == MODE_ADDR);

  always_comb begin
    state_d     = state_q;
    state_d.clr = 1'b0;
    if (hit) begin
      state_d.ctl = reg_wdata[CTL_MSB:CTL_LSB];
      state_d.clr = reg_wdata[CLR_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    reg_rdata                  = '0;
    reg_rdata[CTL_MSB:CTL_LSB] = state_q.ctl;
    reg_rdata[CLR_POS]         = state_q.clr;
  end

  assign clr_req = state_q.clr;

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int HI_BITS = 14,
  parameter int LO_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_zero,
  input  logic               step,
  input  logic               slow_mode,
  output logic               carry,
  output logic [HI_BITS-1:0] cnt
);

  logic [HI_BITS-1:0] cnt_q;
  logic [HI_BITS-1:0] cnt_d;
  logic [HI_BITS-1:0] limit;

  generate
    if (HI_BITS == LO_BITS) begin : g_same_len
      assign limit = '1;
    end else begin : g_two_len
      localparam logic [HI_BITS-1:0] LIM_HI = '1;
      localparam logic [HI_BITS-1:0] LIM_LO =
        {{(HI_BITS-LO_BITS){1'b0}}, {LO_BITS{1'b1}}};
      assign limit = slow_mode ? LIM_LO : LIM_HI;
    end
  endgenerate

  assign carry = step && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (hold_zero) begin
      cnt_d = '0;
    end else if (carry) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wdt_final_stage.sv
module wdt_final_stage #(
  parameter int FIN_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_zero,
  input  logic                step,
  output logic                wrap,
  output logic [FIN_BITS-1:0] cnt
);

  localparam logic [FIN_BITS-1:0] LAST = '1;

  logic [FIN_BITS-1:0] cnt_q;
  logic [FIN_BITS-1:0] cnt_d;

  assign wrap = step && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (hold_zero) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'hCA,
  parameter int                PRE_HI_BITS = 14,
  parameter int                PRE_LO_BITS = 8,
  parameter int                FIN_BITS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cfg_enable,
  input  logic              cfg_slow,
  input  logic              powerdown,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              wdt_reset
);

  logic                   clr_req;
  logic                   hold_zero;
  logic                   pre_step;
  logic                   pre_carry;
  logic                   fin_wrap;
  logic [PRE_HI_BITS-1:0] pre_cnt;
  logic [FIN_BITS-1:0]    fin_cnt;
  logic                   pulse_q;
  logic                   pulse_d;

  wdt_mode_reg #(
    .ADDR_W    (ADDR_W),
    .MODE_ADDR (MODE_ADDR)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clr_req   (clr_req)
  );

  assign hold_zero = !cfg_enable || clr_req;
  assign pre_step  = tick_en && !powerdown && !hold_zero;

  wdt_prescaler #(
    .HI_BITS (PRE_HI_BITS),
    .LO_BITS (PRE_LO_BITS)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (hold_zero),
    .step      (pre_step),
    .slow_mode (cfg_slow),
    .carry     (pre_carry),
    .cnt       (pre_cnt)
  );

  wdt_final_stage #(
    .FIN_BITS (FIN_BITS)
  ) u_fin (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (hold_zero),
    .step      (pre_carry),
    .wrap      (fin_wrap),
    .cnt       (fin_cnt)
  );

  assign pulse_d = fin_wrap && cfg_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign wdt_reset = pulse_q;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'hCA,
  parameter int                PRE_HI_BITS = 14,
  parameter int                FIN_BITS    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_en,
  input logic                   cfg_enable,
  input logic                   powerdown,
  input logic                   reg_wr,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [7:0]             reg_wdata,
  input logic [7:0]             reg_rdata,
  input logic                   wdt_reset,
  input logic [PRE_HI_BITS-1:0] pre_cnt,
  input logic [FIN_BITS-1:0]    fin_cnt
);

  logic set_clr;
  assign set_clr = reg_wr && (reg_addr == MODE_ADDR) && reg_wdata[6];

  // R4: reset request lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  // R4: both stages are back at zero while the request is high
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> (pre_cnt == '0 && fin_cnt == '0));

  // R5: a visible clear bit empties both stages on the next edge
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] |=> (pre_cnt == '0 && fin_cnt == '0));

  // R7: clear bit drops back unless written again
  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[6] && !set_clr) |=> !reg_rdata[6]);

  // R9: power-down freezes the count
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (powerdown && cfg_enable && !reg_rdata[6]) |=>
      ($stable(pre_cnt) && $stable(fin_cnt)));

  // R10: disabled watchdog holds zero and stays quiet
  a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (pre_cnt == '0 && fin_cnt == '0 && !wdt_reset));

  // R11: no tick, no count change
  a_r11_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && cfg_enable && !reg_rdata[6]) |=>
      ($stable(pre_cnt) && $stable(fin_cnt)));

endmodule

bind wdt_guard wdt_guard_chk #(
  .ADDR_W      (ADDR_W),
  .MODE_ADDR   (MODE_ADDR),
  .PRE_HI_BITS (PRE_HI_BITS),
  .FIN_BITS    (FIN_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .cfg_enable (cfg_enable),
  .powerdown  (powerdown),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .wdt_reset  (wdt_reset),
  .pre_cnt    (pre_cnt),
  .fin_cnt    (fin_cnt)
);

// File: tb/tb_wdt_guard.sv
`timescale 1ns/1ps
module tb_wdt_guard;

  localparam int          HI   = 6;
  localparam int          LO   = 3;
  localparam int          FIN  = 4;
  localparam logic [7:0]  ADDR = 8'hCA;
  localparam int          P_HI = (1 << HI) * (1 << FIN);
  localparam int          P_LO = (1 << LO) * (1 << FIN);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cfg_enable = 1'b1;
  logic       cfg_slow = 1'b0;
  logic       powerdown = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wdt_reset;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  // reference model state
  int         m_cnt = 0;
  bit         m_clr = 1'b0;
  bit [2:0]   m_ctl = 3'b000;
  bit         m_pulse = 1'b0;

  always #5 clk = ~clk;

  wdt_guard #(
    .ADDR_W(8), .MODE_ADDR(ADDR),
    .PRE_HI_BITS(HI), .PRE_LO_BITS(LO), .FIN_BITS(FIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cfg_enable(cfg_enable), .cfg_slow(cfg_slow), .powerdown(powerdown),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wdt_reset(wdt_reset)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model updated each edge, compared shortly after
  always @(posedge clk) begin
    int  period;
    bit  np;
    np = 1'b0;
    period = cfg_slow ? P_LO : P_HI;
    if (!rst_n) begin
      m_cnt = 0; m_clr = 1'b0; m_ctl = 3'b000;
    end else begin
      if (!cfg_enable || m_clr) m_cnt = 0;
      else if (tick_en && !powerdown) begin
        if (m_cnt == period - 1) begin m_cnt = 0; np = 1'b1; end
        else m_cnt = m_cnt + 1;
      end
      if (reg_wr && reg_addr == ADDR) begin
        m_ctl = reg_wdata[3:1];
        m_clr = reg_wdata[6];
      end else m_clr = 1'b0;
    end
    m_pulse = np;
    #2;
    check("R2 R3 R4 wdt_reset per-cycle", int'(wdt_reset), int'(m_pulse));
    check("R8 R7 reg_rdata per-cycle", int'(reg_rdata),
          int'({1'b0, m_clr, 2'b00, m_ctl, 1'b0}));
    if (wdt_reset) pulses++;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1; reg_wr = 1'b0;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; reg_wr = 1'b0; powerdown = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    pulses = 0;
  endtask

  task automatic expect_period(input string tag, input int p);
    pulses = 0;
    ticks(p - 1); idle(2);
    check({tag, " no pulse before period"}, pulses, 0);
    ticks(1); idle(2);
    check({tag, " pulse at period"}, pulses, 1);
  endtask

  task automatic main_seq();
    do_reset();
    check("R1 rdata after reset", int'(reg_rdata), 0);
    check("R1 wdt_reset after reset", int'(wdt_reset), 0);

    expect_period("R2 fast", P_HI);
    expect_period("R4 second period", P_HI);

    cfg_slow = 1'b1; do_reset();
    expect_period("R3 slow", P_LO);

    // R5 clear mid period
    pulses = 0;
    ticks(P_LO - 5); wr(ADDR, 8'h40); idle(1);
    expect_period("R5 after clear", P_LO);

    // R6 zero clear bit keeps count
    pulses = 0;
    ticks(P_LO - 5); wr(ADDR, 8'h0E); ticks(4); idle(2);
    check("R6 no pulse yet", pulses, 0);
    ticks(1); idle(2);
    check("R6 pulse on schedule", pulses, 1);

    // R12 other address ignored
    pulses = 0;
    ticks(P_LO - 5); wr(8'hC9, 8'hFF); ticks(4); idle(2);
    check("R12 no pulse yet", pulses, 0);
    check("R12 register unchanged", int'(reg_rdata), 8'h0E);
    ticks(1); idle(2);
    check("R12 pulse on schedule", pulses, 1);

    // R7 and R8 readback
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR; reg_wdata = 8'hFF;
    @(posedge clk); #2;
    check("R7 clear bit visible", int'(reg_rdata), 8'h4E);
    @(negedge clk); reg_wr = 1'b0;
    @(posedge clk); #2;
    check("R7 clear bit dropped", int'(reg_rdata), 8'h0E);
    check("R8 reserved bits zero", int'(reg_rdata & 8'hB1), 0);
    wr(ADDR, 8'h04);
    idle(1);
    check("R8 ctl bits hold", int'(reg_rdata), 8'h04);

    // R9 power-down freeze
    pulses = 0; idle(1);
    ticks(P_LO - 1);
    @(negedge clk); powerdown = 1'b1;
    ticks(20); idle(2);
    check("R9 no count in power-down", pulses, 0);
    @(negedge clk); powerdown = 1'b0;
    ticks(1); idle(2);
    check("R9 resume from kept count", pulses, 1);

    // R11 idle cycles do not count
    pulses = 0;
    ticks(P_LO - 1); idle(50);
    check("R11 no pulse over idle", pulses, 0);
    ticks(1); idle(2);
    check("R11 pulse on next tick", pulses, 1);

    // R10 disabled
    pulses = 0;
    ticks(P_LO - 3);
    @(negedge clk); cfg_enable = 1'b0;
    ticks(2 * P_LO); idle(2);
    check("R10 quiet while disabled", pulses, 0);
    @(negedge clk); cfg_enable = 1'b1;
    expect_period("R10 full period after enable", P_LO);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout R1 actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule